// File: doc/BRIEF.md
# Flash Controller Interrupt Status and Mask Unit

This unit gathers the condition flags of a serial flash controller's transmit, receive and command queues into a single interrupt status word. It also keeps a mask word that software changes only through two write-only strobe registers, and it drives one level-sensitive interrupt line. The surrounding controller supplies the occupancy count of each queue and a one-cycle pulse when a status poll times out. Most flags are derived live from the occupancy counts and three programmable thresholds. The timeout flag is the only sticky one, and software clears it by writing a one to it.

Software reaches the unit through a plain register port. A write takes effect at the clock edge where `reg_wr` is high. A read is requested by `reg_rd`, and its data appears on `reg_rdata` after that edge, where it stays until the next read. No stream data passes through the block, so every pin is a plain control or status signal. There is no back-pressure anywhere: each register access completes in one cycle.

Register addresses on `reg_addr` are as follows:
- 0: status (read; write-one-to-clear for the timeout bit)
- 1: unmask strobe (write-only)
- 2: mask strobe (write-only)
- 3: mask readback
- 4: transmit threshold
- 5: receive threshold
- 6: command threshold
- 7: reserved

Top module: `flash_irq_unit`

## Requirements
- R1: After reset, the mask reads 0xFBE (every source disabled), `irq` is low, and the transmit, receive and command thresholds read 1, 1 and 16.
- R2: Status bits report queue extremes. Bit 3 is set when transmit occupancy equals its depth (64). Bit 5 is set when receive occupancy equals its depth (64). Bit 10 is set when command occupancy equals its depth (32). Bit 8 is set when transmit occupancy is 0, bit 11 when receive occupancy is 0, and bit 7 when command occupancy is 0.
- R3: Status bit 2 is set while transmit occupancy is below the transmit threshold. Status bit 9 is set while command occupancy is below the command threshold.
- R4: Status bit 4 is set while receive occupancy is at or above the receive threshold.
- R5: Status bit 1 becomes set on the cycle after a `poll_expire` pulse. It stays set until a write to address 0 with data bit 1 at one. A write to address 0 changes no other status bit. If a pulse and a clear land in the same cycle, the bit stays set.
- R6: A write to address 1 clears every mask bit whose data bit is one and leaves the other mask bits alone.
- R7: A write to address 2 sets every implemented mask bit whose data bit is one and leaves the other mask bits alone.
- R8: Bit positions outside the pattern 0xFBE (bits 0, 6 and 12 to 31) are not implemented. They always read 0 in both status and mask, and writes to them have no effect.
- R9: `irq` is high exactly when, on the previous clock edge, some status bit was set whose mask bit was 0.
- R10: Reads return data one cycle after the request. Addresses 1, 2 and 7 read as 0. The threshold registers read back the last value written, truncated to the occupancy width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_level | input | 7 | Transmit queue occupancy |
| rx_level | input | 7 | Receive queue occupancy |
| cmd_level | input | 6 | Command queue occupancy |
| poll_expire | input | 1 | One-cycle poll timeout pulse |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong threshold comparison or stale sticky bit shows up in the status word on the first read after the occupancy changes, and in `irq` one edge later once the source is unmasked. A corrupted mask register is visible directly through the mask readback. It also shows as `irq` asserting or failing to assert on the edge after the strobe write. Each occupancy boundary (threshold minus one, threshold, depth, zero) is therefore checked through a status read, and each mask change through both the readback and the interrupt line.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned B_POLL     = 1;
  localparam int unsigned B_TX_NFULL = 2;
  localparam int unsigned B_TX_FULL  = 3;
  localparam int unsigned B_RX_NEMP  = 4;
  localparam int unsigned B_RX_FULL  = 5;
  localparam int unsigned B_CQ_EMPTY = 7;
  localparam int unsigned B_TX_EMPTY = 8;
  localparam int unsigned B_CQ_NFULL = 9;
  localparam int unsigned B_CQ_FULL  = 10;
  localparam int unsigned B_RX_EMPTY = 11;

  localparam logic [WORD_W-1:0] SRC_BITS = 32'h0000_0FBE;

  localparam logic [2:0] A_STATUS  = 3'd0;
  localparam logic [2:0] A_UNMASK  = 3'd1;
  localparam logic [2:0] A_MASKSET = 3'd2;
  localparam logic [2:0] A_MASK    = 3'd3;
  localparam logic [2:0] A_TX_THR  = 3'd4;
  localparam logic [2:0] A_RX_THR  = 3'd5;
  localparam logic [2:0] A_CQ_THR  = 3'd6;
endpackage

// File: rtl/flash_irq_thresh.sv
module flash_irq_thresh #(
  parameter int unsigned W       = 7,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)  value <= W'(RST_VAL);
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/flash_irq_flags.sv
module flash_irq_flags
  import flash_irq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 64,
  parameter int unsigned RX_DEPTH = 64,
  parameter int unsigned CQ_DEPTH = 32,
  localparam int unsigned TXW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RXW = $clog2(RX_DEPTH + 1),
  localparam int unsigned CQW = $clog2(CQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TXW-1:0]    tx_level,
  input  logic [RXW-1:0]    rx_level,
  input  logic [CQW-1:0]    cq_level,
  input  logic [TXW-1:0]    tx_thr,
  input  logic [RXW-1:0]    rx_thr,
  input  logic [CQW-1:0]    cq_thr,
  input  logic              poll_set,
  input  logic              poll_clr,
  output logic [WORD_W-1:0] status
);
  localparam logic [TXW-1:0] TX_TOP = TXW'(TX_DEPTH);
  localparam logic [RXW-1:0] RX_TOP = RXW'(RX_DEPTH);
  localparam logic [CQW-1:0] CQ_TOP = CQW'(CQ_DEPTH);

  logic sticky_q;

  // Set has priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)        sticky_q <= 1'b0;
    else if (poll_set) sticky_q <= 1'b1;
    else if (poll_clr) sticky_q <= 1'b0;
  end

  always_comb begin
    status             = '0;
    status[B_POLL]     = sticky_q;
    status[B_TX_NFULL] = (tx_level < tx_thr);
    status[B_TX_FULL]  = (tx_level == TX_TOP);
    status[B_RX_NEMP]  = (rx_level >= rx_thr);
    status[B_RX_FULL]  = (rx_level == RX_TOP);
    status[B_CQ_EMPTY] = (cq_level == '0);
    status[B_TX_EMPTY] = (tx_level == '0);
    status[B_CQ_NFULL] = (cq_level < cq_thr);
    status[B_CQ_FULL]  = (cq_level == CQ_TOP);
    status[B_RX_EMPTY] = (rx_level == '0);
  end
endmodule

// File: rtl/flash_irq_mask.sv
module flash_irq_mask
  import flash_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unmask_we,
  input  logic              maskset_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] mask
);
  logic [WORD_W-1:0] sel;
  assign sel = wdata & SRC_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n)          mask <= SRC_BITS;
    else if (unmask_we)  mask <= mask & ~sel;
    else if (maskset_we) mask <= mask | sel;
  end
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
  import flash_irq_pkg::*;
#(
  parameter int unsigned TX_DEPTH   = 64,
  parameter int unsigned RX_DEPTH   = 64,
  parameter int unsigned CQ_DEPTH   = 32,
  parameter int unsigned TX_THR_RST = 1,
  parameter int unsigned RX_THR_RST = 1,
  parameter int unsigned CQ_THR_RST = 16,
  localparam int unsigned TXW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RXW = $clog2(RX_DEPTH + 1),
  localparam int unsigned CQW = $clog2(CQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [TXW-1:0]    tx_level,
  input  logic [RXW-1:0]    rx_level,
  input  logic [CQW-1:0]    cmd_level,
  input  logic              poll_expire,
  output logic              irq
);
  logic [TXW-1:0]    tx_thr;
  logic [RXW-1:0]    rx_thr;
  logic [CQW-1:0]    cq_thr;
  logic [WORD_W-1:0] status_w;
  logic [WORD_W-1:0] mask_w;
  logic [WORD_W-1:0] rd_mux;
  logic              wr_status;

  assign wr_status = reg_wr && (reg_addr == A_STATUS);

  flash_irq_thresh #(.W(TXW), .RST_VAL(TX_THR_RST)) u_tx_thr (
    .clk(clk), .rst_n(rst_n), .we(reg_wr && reg_addr == A_TX_THR),
    .wdata(reg_wdata[TXW-1:0]), .value(tx_thr));

  flash_irq_thresh #(.W(RXW), .RST_VAL(RX_THR_RST)) u_rx_thr (
    .clk(clk), .rst_n(rst_n), .we(reg_wr && reg_addr == A_RX_THR),
    .wdata(reg_wdata[RXW-1:0]), .value(rx_thr));

  flash_irq_thresh #(.W(CQW), .RST_VAL(CQ_THR_RST)) u_cq_thr (
    .clk(clk), .rst_n(rst_n), .we(reg_wr && reg_addr == A_CQ_THR),
    .wdata(reg_wdata[CQW-1:0]), .value(cq_thr));

  flash_irq_flags #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .CQ_DEPTH(CQ_DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .rx_level(rx_level), .cq_level(cmd_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .cq_thr(cq_thr),
    .poll_set(poll_expire), .poll_clr(wr_status && reg_wdata[B_POLL]),
    .status(status_w));

  flash_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .unmask_we(reg_wr && reg_addr == A_UNMASK),
    .maskset_we(reg_wr && reg_addr == A_MASKSET),
    .wdata(reg_wdata), .mask(mask_w));

  always_comb begin
    case (reg_addr)
      A_STATUS: rd_mux = status_w;
      A_MASK:   rd_mux = mask_w;
      A_TX_THR: rd_mux = WORD_W'(tx_thr);
      A_RX_THR: rd_mux = WORD_W'(rx_thr);
      A_CQ_THR: rd_mux = WORD_W'(cq_thr);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= |(status_w & ~mask_w);
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/flash_irq_unit_chk.sv
module flash_irq_unit_chk
  import flash_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              poll_expire,
  input logic [WORD_W-1:0] status,
  input logic [WORD_W-1:0] mask,
  input logic              irq
);
  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(status) & ~$past(mask))));

  p_poll_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expire |=> status[B_POLL]);

  p_poll_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_POLL] && !(reg_wr && reg_addr == A_STATUS && reg_wdata[B_POLL]))
      |=> status[B_POLL]);

  p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_UNMASK) |=> ((mask & $past(reg_wdata)) == '0));

  p_maskset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MASKSET)
      |=> ((mask & $past(reg_wdata) & SRC_BITS) == ($past(reg_wdata) & SRC_BITS)));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == A_UNMASK || reg_addr == A_MASKSET)) |=> $stable(mask));

  p_unimpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask | status) & ~SRC_BITS) == '0);
endmodule

bind flash_irq_unit flash_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .poll_expire(poll_expire),
  .status(status_w), .mask(mask_w), .irq(irq));

// File: tb/flash_irq_unit_bench.sv
`timescale 1ns/1ps
module flash_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  tx_level = '0, rx_level = '0;
  logic [5:0]  cmd_level = '0;
  logic        poll_expire = 1'b0;
  logic        irq;

  always #2 clk = ~clk;

  flash_irq_unit u_flash_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .cmd_level(cmd_level),
    .poll_expire(poll_expire), .irq(irq));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  logic rd_seen = 1'b0;

  // Model state derived from the requirements.
  int m_txt = 1, m_rxt = 1, m_cqt = 16;
  bit m_stk = 0;
  logic [31:0] m_mask = 32'hFBE;

  function automatic logic [31:0] model_status();
    logic [31:0] s = '0;
    s[1]  = m_stk;
    s[2]  = int'(tx_level) < m_txt;
    s[3]  = tx_level == 64;
    s[4]  = int'(rx_level) >= m_rxt;
    s[5]  = rx_level == 64;
    s[7]  = cmd_level == 0;
    s[8]  = tx_level == 0;
    s[9]  = int'(cmd_level) < m_cqt;
    s[10] = cmd_level == 32;
    s[11] = rx_level == 0;
    return s;
  endfunction

  always @(posedge clk) rd_seen <= reg_rd;

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected read data %h", "R10", reg_rdata);
      end else begin
        e = q.pop_front();
        if (reg_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: read got %h expected %h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    logic exp;
    repeat (2) @(negedge clk);
    exp = |(model_status() & ~m_mask);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic lv(input int t, input int r, input int c);
    @(negedge clk);
    tx_level = 7'(t); rx_level = 7'(r); cmd_level = 6'(c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R1: irq got %b expected 0", irq); end
    rd(3'd3, 32'hFBE, "R1 mask");
    rd(3'd4, 32'd1, "R1 tx thr");
    rd(3'd5, 32'd1, "R1 rx thr");
    rd(3'd6, 32'd16, "R1 cmd thr");
    rd(3'd0, 32'hB84, "R2 empty status");
    // R2 full
    lv(64, 64, 32);
    rd(3'd0, 32'h438, "R2 full status");
    // R10 write-only and reserved read 0
    rd(3'd1, 32'h0, "R10 unmask reads zero");
    rd(3'd2, 32'h0, "R10 maskset reads zero");
    rd(3'd7, 32'h0, "R10 reserved");
    // R3/R4 thresholds
    wr(3'd4, 32'd32); m_txt = 32;
    wr(3'd5, 32'hFFFF_FFA0); m_rxt = 32; // truncated to 7 bits = 32
    rd(3'd4, 32'd32, "R10 tx thr readback");
    rd(3'd5, 32'd32, "R10 rx thr truncated");
    lv(31, 31, 15);
    rd(3'd0, model_status(), "R3 R4 below thresholds");
    lv(32, 32, 16);
    rd(3'd0, model_status(), "R3 R4 at thresholds");
    // R6 unmask rx-not-empty, irq follows
    wr(3'd1, 32'h10); m_mask = 32'hFAE;
    rd(3'd3, 32'hFAE, "R6 mask after unmask");
    chk_irq("R9 irq unmasked source");
    lv(32, 31, 16);
    chk_irq("R9 irq drops with source");
    lv(32, 32, 16);
    chk_irq("R9 irq returns");
    // R7 mask again
    wr(3'd2, 32'h10); m_mask = 32'hFBE;
    rd(3'd3, 32'hFBE, "R7 mask after set");
    chk_irq("R7 irq masked");
    // R8 unimplemented
    wr(3'd1, 32'hFFFF_FFFF); m_mask = 32'h0;
    rd(3'd3, 32'h0, "R6 unmask all");
    wr(3'd2, 32'hFFFF_F041); m_mask = 32'h0;
    rd(3'd3, 32'h0, "R8 unimplemented writes ignored");
    wr(3'd2, 32'hFFFF_FFFF); m_mask = 32'hFBE;
    rd(3'd3, 32'hFBE, "R7 R8 mask all");
    // R5 sticky timeout
    wr(3'd1, 32'h2); m_mask = 32'hFBC;
    chk_irq("R5 no timeout yet");
    @(negedge clk); poll_expire = 1'b1;
    @(negedge clk); poll_expire = 1'b0; m_stk = 1;
    repeat (4) @(negedge clk);
    rd(3'd0, model_status(), "R5 timeout held");
    chk_irq("R5 R9 timeout raises irq");
    wr(3'd0, 32'hFFFF_FFFD);
    rd(3'd0, model_status(), "R5 clear without bit1 ignored");
    wr(3'd0, 32'h2); m_stk = 0;
    rd(3'd0, model_status(), "R5 cleared");
    chk_irq("R5 irq after clear");
    // R5 set wins
    @(negedge clk);
    poll_expire = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h2;
    @(negedge clk);
    poll_expire = 1'b0; reg_wr = 1'b0; m_stk = 1;
    rd(3'd0, model_status(), "R5 set beats clear");
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin errors++; $display("FAIL R10: %0d reads unanswered, expected 0", q.size()); end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule